// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives 32-bit management frames to PHY or SerDes devices over a two-wire management bus. Software programs a control word (preamble enable and MDC clock divisor) and then writes a single 32-bit command word that already holds the start marker, the operation bits, the device and register addresses, the turnaround request and, for writes, the 16-bit payload. The block serializes the frame on MDC/MDIO. For a read it releases the data line, captures the 16 data bits driven by the device, and places them in the low half of the command register. A read-only completion flag tells software when the transaction has finished. Retry and timeout policy remain in software.

A build-time mode selects extended addressing. In that mode the device number is not placed in the access frame. Instead, a separate select frame is sent first: a write to register 0x1F of device 0 that carries the device number in data bits 8:4. The access frame follows with a zero device field.

Top module: `mdio_frame_master`

## Requirements
- R1: After synchronous reset, the control word (offset 0) and the command word (offset 1) both read zero, MDC is low and the MDIO output enable is low.
- R2: Control bits 6:0 hold the divisor D. Each MDC half period lasts D+1 system clocks, so the MDC period is 2*(D+1) clocks. MDC stays low while no frame is in progress.
- R3: When control bit 7 is set, each frame begins with 32 one bits driven on MDIO. When bit 7 is clear, the frame begins directly with its start field.
- R4: In the default mode, a command word with bit 30 set starts a frame. The frame bits, in wire order, are: start field 01, op = command bits 29:28 (10 read, 01 write), device = bits 26:22, register = 0 followed by bits 21:18, turnaround = {bit 17, 0}, then bits 15:0 for a write.
- R5: In a read (command bit 29 set), the output enable is low for the two turnaround bit times and all 16 data bit times. The 16 sampled bits, MSB first, then read back from command-word bits 15:0, while bits 31:16 keep their written value.
- R6: Control bit 8 is read-only. It is 0 after reset, sets when the last frame of a transaction ends, and clears when the next transaction starts. Writing the control word does not change it.
- R7: A command-word write made while a transaction is in progress is ignored. It starts no frame and leaves the stored command word unchanged.
- R8: With extended addressing built in, each transaction first sends a write frame to device 0, register 0x1F, turnaround 10, with data = command bits 27:23 placed at bits 8:4. The access frame then follows, with device field 0 and register = command bits 22:18.
- R9: MDIO and its output enable change only while MDC is low. They are stable while MDC is high, and the line is sampled on the MDC rising edge.
- R10: A command-word write with bit 30 clear is stored and reads back unchanged, but it starts no frame and does not change the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word offset: 0 control, 1 command |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench builds two instances side by side, both with the default 32-bit preamble length. One uses the default addressing mode (EXT_MODE=0). The other uses extended addressing (EXT_MODE=1), which brings the select-then-access frame pair and the zeroed device field within reach. Divisor values 0, 1, 2 and 5 are programmed through the control word, so both the shortest MDC timing and the stretched timings are covered. Reads return known patterns from a device model that decodes every frame from the wire.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;

    localparam int FRAME_BITS = 32;
    localparam int DIV_W      = 7;
    localparam int TA_POS     = 14;
    localparam int DATA_POS   = 16;

    localparam int CTRL_OFS   = 0;
    localparam int DATA_OFS   = 1;

    localparam int CTL_PRE    = 7;
    localparam int CTL_DONE   = 8;

    localparam int CMD_START  = 30;
    localparam int CMD_RD     = 29;
    localparam int CMD_TA     = 17;

    localparam logic [4:0] SEL_REG = 5'h1F;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_SELECT = 2'd1,
        SQ_ACCESS = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [FRAME_BITS-1:0] bits;
        logic                  rd;
    } mdio_frame_t;

    typedef struct packed {
        logic             pre_en;
        logic [DIV_W-1:0] div;
    } mdio_ctrl_t;

    function automatic mdio_frame_t access_frame(input logic [31:0] c, input logic ext);
        mdio_frame_t f;
        logic [4:0]  dev;
        logic [4:0]  reg_a;
        logic        rd;
        rd = c[CMD_RD];
        if (ext) begin
            dev   = 5'd0;
            reg_a = c[22:18];
        end else begin
            dev   = c[26:22];
            reg_a = {1'b0, c[21:18]};
        end
        f.rd   = rd;
        f.bits = {2'b01, c[29:28], dev, reg_a, c[CMD_TA], 1'b0,
                  (rd ? 16'h0000 : c[15:0])};
        return f;
    endfunction

    function automatic mdio_frame_t select_frame(input logic [31:0] c);
        mdio_frame_t f;
        f.rd   = 1'b0;
        f.bits = {2'b01, 2'b01, 5'd0, SEL_REG, 2'b10, 7'd0, c[27:23], 4'd0};
        return f;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
    parameter int DW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] div,
    output logic          mdc,
    output logic          tick_rise,
    output logic          tick_fall
);
    logic [DW-1:0] cnt_q;
    logic          mdc_q;
    logic          tick;

    assign tick      = en && (cnt_q == div);
    assign tick_rise = tick && !mdc_q;
    assign tick_fall = tick && mdc_q;
    assign mdc       = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: the clock parks low once the engine is disabled
    a_r2_mdc_idle_low: assert property (@(posedge clk) disable iff (rst)
        !en |=> !mdc);

endmodule

// File: rtl/mdio_frame_shifter.sv
`timescale 1ns/1ps
module mdio_frame_shifter
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  mdio_frame_t      frame,
    input  logic             pre_en,
    input  logic [DIV_W-1:0] div,
    input  logic             mdio_i,
    output logic             busy,
    output logic             fin,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic [15:0]      rd_data
);
    localparam int IDX_W = $clog2(PRE_LEN + FRAME_BITS + 1);
    localparam int POS_W = $clog2(FRAME_BITS);

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] npre_q;
    mdio_frame_t      frm_q;
    logic [DIV_W-1:0] div_q;
    logic [15:0]      cap_q;

    logic             tick_rise;
    logic             tick_fall;
    logic [IDX_W-1:0] rel_idx;
    logic [IDX_W-1:0] last_idx;
    logic [POS_W-1:0] pos;
    logic             in_pre;
    logic             released;
    logic             cur_bit;

    mdio_mdc_gen #(.DW(DIV_W)) u_mdc (
        .clk       (clk),
        .rst       (rst),
        .en        (busy_q),
        .div       (div_q),
        .mdc       (mdc),
        .tick_rise (tick_rise),
        .tick_fall (tick_fall)
    );

    always_comb begin
        in_pre   = idx_q < npre_q;
        rel_idx  = idx_q - npre_q;
        last_idx = npre_q + IDX_W'(FRAME_BITS - 1);
        pos      = ~POS_W'(rel_idx);
        cur_bit  = in_pre ? 1'b1 : frm_q.bits[pos];
        released = frm_q.rd && !in_pre && (rel_idx >= IDX_W'(TA_POS));
    end

    assign busy    = busy_q;
    assign fin     = tick_fall && (idx_q == last_idx);
    assign mdio_o  = busy_q && cur_bit && !released;
    assign mdio_oe = busy_q && !released;
    assign rd_data = cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            npre_q <= '0;
            frm_q  <= '0;
            div_q  <= '0;
            cap_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                npre_q <= pre_en ? IDX_W'(PRE_LEN) : '0;
                frm_q  <= frame;
                div_q  <= div;
                cap_q  <= '0;
            end
        end else begin
            if (tick_rise && released && (rel_idx >= IDX_W'(DATA_POS))) begin
                cap_q <= {cap_q[14:0], mdio_i};
            end
            if (tick_fall) begin
                if (idx_q == last_idx) begin
                    busy_q <= 1'b0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // R9: line and enable hold while the clock is high
    a_r9_hold_while_high: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R5: the line is released only inside a read frame
    a_r5_release_read_only: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !mdio_oe) |-> frm_q.rd);

endmodule

// File: rtl/mdio_sequencer.sv
`timescale 1ns/1ps
module mdio_sequencer
    import mdio_pkg::*;
#(
    parameter bit EXT_MODE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [31:0]      cmd,
    input  logic             pre_en,
    input  logic [DIV_W-1:0] div,
    input  logic             sh_fin,
    output logic             sh_start,
    output mdio_frame_t      sh_frame,
    output logic             sh_pre_en,
    output logic [DIV_W-1:0] sh_div,
    output logic             busy,
    output logic             acc_fin,
    output logic             acc_rd
);
    seq_state_e       state_q;
    seq_state_e       first_state;
    logic [31:0]      cmd_q;
    logic             pre_q;
    logic [DIV_W-1:0] div_q;
    logic             start_q;

    generate
        if (EXT_MODE) begin : g_ext
            assign first_state = SQ_SELECT;
            always_comb begin
                sh_frame = (state_q == SQ_SELECT) ? select_frame(cmd_q)
                                                  : access_frame(cmd_q, 1'b1);
            end
        end else begin : g_leg
            assign first_state = SQ_ACCESS;
            always_comb begin
                sh_frame = access_frame(cmd_q, 1'b0);
            end
        end
    endgenerate

    assign sh_start  = start_q;
    assign sh_pre_en = pre_q;
    assign sh_div    = div_q;
    assign busy      = state_q != SQ_IDLE;
    assign acc_fin   = (state_q == SQ_ACCESS) && sh_fin;
    assign acc_rd    = cmd_q[CMD_RD];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cmd_q   <= '0;
            pre_q   <= 1'b0;
            div_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (go) begin
                        state_q <= first_state;
                        cmd_q   <= cmd;
                        pre_q   <= pre_en;
                        div_q   <= div;
                        start_q <= 1'b1;
                    end
                end
                SQ_SELECT: begin
                    if (sh_fin) begin
                        state_q <= SQ_ACCESS;
                        start_q <= 1'b1;
                    end
                end
                SQ_ACCESS: begin
                    if (sh_fin) state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // R8: the select frame is always followed by the access frame
    a_r8_access_after_select: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_SELECT && sh_fin) |=> (state_q == SQ_ACCESS && sh_start));

endmodule

// File: rtl/mdio_frame_master.sv
`timescale 1ns/1ps
module mdio_frame_master
    import mdio_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int PRE_LEN  = 32,
    parameter bit EXT_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    mdio_ctrl_t       ctrl_q;
    logic             done_q;
    logic [31:0]      data_q;

    logic             wr_ctrl;
    logic             wr_data;
    logic             go;
    logic             seq_busy;
    logic             seq_fin;
    logic             seq_rd;
    logic             sh_start;
    mdio_frame_t      sh_frame;
    logic             sh_pre_en;
    logic [DIV_W-1:0] sh_div;
    logic             sh_fin;
    logic             sh_busy;
    logic [15:0]      sh_rd_data;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(CTRL_OFS));
    assign wr_data = reg_wr && (reg_addr == ADDR_W'(DATA_OFS));
    assign go      = wr_data && !seq_busy && reg_wdata[CMD_START];

    mdio_sequencer #(.EXT_MODE(EXT_MODE)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .cmd       (reg_wdata),
        .pre_en    (ctrl_q.pre_en),
        .div       (ctrl_q.div),
        .sh_fin    (sh_fin),
        .sh_start  (sh_start),
        .sh_frame  (sh_frame),
        .sh_pre_en (sh_pre_en),
        .sh_div    (sh_div),
        .busy      (seq_busy),
        .acc_fin   (seq_fin),
        .acc_rd    (seq_rd)
    );

    mdio_frame_shifter #(.PRE_LEN(PRE_LEN)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (sh_start),
        .frame   (sh_frame),
        .pre_en  (sh_pre_en),
        .div     (sh_div),
        .mdio_i  (mdio_i),
        .busy    (sh_busy),
        .fin     (sh_fin),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rd_data (sh_rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            done_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.pre_en <= reg_wdata[CTL_PRE];
                ctrl_q.div    <= reg_wdata[DIV_W-1:0];
            end
            if (wr_data && !seq_busy) begin
                data_q <= reg_wdata;
            end
            if (go) begin
                done_q <= 1'b0;
            end else if (seq_fin) begin
                done_q <= 1'b1;
                if (seq_rd) data_q[15:0] <= sh_rd_data;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(CTRL_OFS)) begin
            reg_rdata[CTL_DONE]  = done_q;
            reg_rdata[CTL_PRE]   = ctrl_q.pre_en;
            reg_rdata[DIV_W-1:0] = ctrl_q.div;
        end else if (reg_addr == ADDR_W'(DATA_OFS)) begin
            reg_rdata = data_q;
        end
    end

    // R7: command writes during a transaction leave the stored word alone
    a_r7_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (seq_busy && wr_data && !seq_fin) |=> $stable(data_q));

    // R6: completion rises only as the transaction winds down
    a_r6_done_at_end: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> (!seq_busy && $past(seq_busy)));

    // R6: completion drops only when a new transaction begins
    a_r6_done_clear_on_start: assert property (@(posedge clk) disable iff (rst)
        $fell(done_q) |-> $rose(seq_busy));

    // R2: the shifter never runs outside a transaction
    a_r2_shift_inside_txn: assert property (@(posedge clk) disable iff (rst)
        sh_busy |-> seq_busy);

endmodule

// File: tb/mdio_frame_master_tb_top.sv
`timescale 1ns/1ps
module mdio_phy_model (
    input  logic        mdc,
    input  logic        mdo,
    input  logic        oe,
    input  logic [15:0] rd_value,
    output logic        mdi,
    output int          obs_count,
    output logic [31:0] obs_frame,
    output int          obs_pre,
    output logic        obs_rdok
);
    logic        in_frm;
    int          nb;
    int          pre;
    logic [31:0] sh;
    logic        is_rd;
    logic        rdok;
    logic        bitv;

    initial begin
        mdi = 1'b0; obs_count = 0; obs_frame = '0; obs_pre = 0; obs_rdok = 1'b1;
        in_frm = 1'b0; nb = 0; pre = 0; sh = '0; is_rd = 1'b0; rdok = 1'b1; bitv = 1'b0;
    end

    always @(posedge mdc) begin
        if (!in_frm) begin
            if (oe) begin
                if (mdo) pre++;
                else begin
                    in_frm = 1'b1; sh = '0; nb = 1; rdok = 1'b1; is_rd = 1'b0;
                end
            end
        end else begin
            if (is_rd && nb >= 14) begin
                bitv = 1'b0;
                if (oe) rdok = 1'b0;
            end else begin
                bitv = mdo;
            end
            sh = {sh[30:0], bitv};
            nb++;
            if (nb == 4) is_rd = (sh[1:0] == 2'b10);
            if (nb == 32) begin
                obs_frame = sh; obs_pre = pre; obs_rdok = rdok;
                in_frm = 1'b0; pre = 0;
                obs_count++;
            end
        end
    end

    always @(negedge mdc) begin
        if (in_frm && is_rd && nb >= 16 && nb < 32) mdi = rd_value[31-nb];
        else mdi = 1'b0;
    end
endmodule

module mdio_frame_master_tb_top;
    localparam time TCLK = 8ns;

    typedef struct {
        logic [31:0] frame;
        int          pre;
        logic        rd;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0;
    logic        sel = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_l, rdata_e;
    logic        mdc_l, mdo_l, oe_l, mdi_l;
    logic        mdc_e, mdo_e, oe_e, mdi_e;
    logic [15:0] rdv_l = 16'h0000;
    logic [15:0] rdv_e = 16'h0000;
    int          cnt_l, cnt_e, pre_l, pre_e;
    logic [31:0] fr_l, fr_e;
    logic        rok_l, rok_e;

    int total = 0;
    int bad = 0;
    int viol_l = 0;
    int viol_e = 0;
    bit finished = 0;
    exp_t q_l[$];
    exp_t q_e[$];

    always #(TCLK/2) clk = ~clk;

    mdio_frame_master #(.EXT_MODE(1'b0)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(wr && !sel), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata_l), .mdc(mdc_l), .mdio_o(mdo_l), .mdio_oe(oe_l), .mdio_i(mdi_l));

    mdio_frame_master #(.EXT_MODE(1'b1)) dut_ext_i (
        .clk(clk), .rst(rst), .reg_wr(wr && sel), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata_e), .mdc(mdc_e), .mdio_o(mdo_e), .mdio_oe(oe_e), .mdio_i(mdi_e));

    mdio_phy_model phy_l (.mdc(mdc_l), .mdo(mdo_l), .oe(oe_l), .rd_value(rdv_l), .mdi(mdi_l),
        .obs_count(cnt_l), .obs_frame(fr_l), .obs_pre(pre_l), .obs_rdok(rok_l));
    mdio_phy_model phy_e (.mdc(mdc_e), .mdo(mdo_e), .oe(oe_e), .rd_value(rdv_e), .mdi(mdi_e),
        .obs_count(cnt_e), .obs_frame(fr_e), .obs_pre(pre_e), .obs_rdok(rok_e));

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare(ref exp_t q[$], input logic [31:0] fr, input int pre,
                           input logic rdok, input string who);
        exp_t e;
        if (q.size() == 0) begin
            check(1'b0, "R7", fr, 32'h0, {who, " unexpected frame"});
            return;
        end
        e = q.pop_front();
        check(fr == e.frame, "R4", fr, e.frame, {who, " frame bits"});
        check(pre == e.pre, "R3", pre, e.pre, {who, " preamble ones"});
        if (e.rd) check(rdok == 1'b1, "R5", rdok, 1, {who, " released during turnaround/data"});
    endtask

    // scoreboard monitors
    always @(cnt_l) if (cnt_l > 0) compare(q_l, fr_l, pre_l, rok_l, "legacy");
    always @(cnt_e) if (cnt_e > 0) compare(q_e, fr_e, pre_e, rok_e, "ext");

    // R9 monitor: line must not move while MDC is high
    logic pm_l = 0, po_l = 0, pm_e = 0, po_e = 0;
    always @(negedge clk) begin
        if (((mdo_l != pm_l) || (oe_l != po_l)) && mdc_l) viol_l++;
        if (((mdo_e != pm_e) || (oe_e != po_e)) && mdc_e) viol_e++;
        pm_l = mdo_l; po_l = oe_l; pm_e = mdo_e; po_e = oe_e;
    end

    function automatic logic [31:0] leg_frame(input logic [31:0] c);
        logic rd = c[29];
        return {2'b01, c[29:28], c[26:22], 1'b0, c[21:18],
                (rd ? 2'b00 : {c[17], 1'b0}), (rd ? 16'h0 : c[15:0])};
    endfunction

    function automatic logic [31:0] ext_frame(input logic [31:0] c);
        logic rd = c[29];
        return {2'b01, c[29:28], 5'd0, c[22:18],
                (rd ? 2'b00 : {c[17], 1'b0}), (rd ? 16'h0 : c[15:0])};
    endfunction

    function automatic logic [31:0] sel_frame(input logic [31:0] c);
        return {4'b0101, 5'd0, 5'h1F, 2'b10, 7'd0, c[27:23], 4'd0};
    endfunction

    task automatic reg_write(input logic s, input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = s; addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic s, input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = s; addr = a;
        #1;
        d = s ? rdata_e : rdata_l;
    endtask

    task automatic wait_done(input logic s);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < 5000; i++) begin
            reg_read(s, 2'd0, v);
            if (v[8]) break;
        end
        check(v[8] == 1'b1, "R6", v, 32'h100, "completion flag after transaction");
    endtask

    task automatic issue(input logic s, input logic [31:0] c, input logic pre, input int dv);
        exp_t e;
        int np = pre ? 32 : 0;
        reg_write(s, 2'd0, {24'd0, pre, 7'(dv)});
        if (!s) begin
            e.frame = leg_frame(c); e.pre = np; e.rd = c[29]; q_l.push_back(e);
        end else begin
            e.frame = sel_frame(c); e.pre = np; e.rd = 1'b0; q_e.push_back(e);
            e.frame = ext_frame(c); e.pre = np; e.rd = c[29]; q_e.push_back(e);
        end
        reg_write(s, 2'd1, c);
    endtask

    initial begin
        #(TCLK * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] c;
        time t0, t1;
        int n0;

        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        reg_read(0, 2'd0, v); check(v == 0, "R1", v, 0, "legacy control after reset");
        reg_read(0, 2'd1, v); check(v == 0, "R1", v, 0, "legacy command after reset");
        check({mdc_l, oe_l} == 2'b00, "R1", {mdc_l, oe_l}, 0, "legacy pins after reset");
        reg_read(1, 2'd0, v); check(v == 0, "R1", v, 0, "ext control after reset");

        // R6 read-only completion flag, R2 divisor field
        reg_write(1, 2'd0, 32'h0000_0102);
        reg_read(1, 2'd0, v);
        check(v[8] == 1'b0, "R6", v, 32'h2, "completion bit not writable");
        check(v[6:0] == 7'd2, "R2", v, 32'h2, "divisor field readback");

        // R3/R4 legacy write with preamble, R2 MDC period
        c = 32'h4000_0000 | (32'h1 << 28) | (32'h0B << 22) | (32'h6 << 18) | (32'h1 << 17) | 32'hA5C3;
        issue(0, c, 1'b1, 2);
        @(posedge mdc_l); t0 = $time;
        @(posedge mdc_l); t1 = $time;
        check((t1 - t0) == 6 * TCLK, "R2", 32'(((t1 - t0) / TCLK)), 6, "MDC period divisor 2");
        wait_done(0);
        reg_read(0, 2'd1, v); check(v == c, "R4", v, c, "write leaves command word");

        // R5 legacy read, no preamble, divisor 0; R6 flag clears on start
        rdv_l = 16'h3C96;
        c = 32'h4000_0000 | (32'h1 << 29) | (32'h11 << 22) | (32'hF << 18) | (32'h1 << 17);
        issue(0, c, 1'b0, 0);
        reg_read(0, 2'd0, v); check(v[8] == 1'b0, "R6", v, 0, "flag clears on start");
        wait_done(0);
        reg_read(0, 2'd1, v);
        check(v == {c[31:16], 16'h3C96}, "R5", v, {c[31:16], 16'h3C96}, "read data returned");

        // R7 write during busy ignored, divisor 5 period
        c = 32'h4000_0000 | (32'h1 << 28) | (32'h03 << 22) | (32'h2 << 18) | (32'h1 << 17) | 32'h0F0F;
        n0 = cnt_l;
        issue(0, c, 1'b1, 5);
        reg_write(0, 2'd1, 32'h6000_0000 | (32'h1F << 22));
        @(posedge mdc_l); t0 = $time;
        @(posedge mdc_l); t1 = $time;
        check((t1 - t0) == 12 * TCLK, "R2", 32'(((t1 - t0) / TCLK)), 12, "MDC period divisor 5");
        wait_done(0);
        repeat (900) @(posedge clk);
        check(cnt_l - n0 == 1, "R7", cnt_l - n0, 1, "frames after busy write");
        reg_read(0, 2'd1, v); check(v == c, "R7", v, c, "command word kept");

        // R10 start bit clear
        n0 = cnt_l;
        reg_write(0, 2'd1, 32'h1000_1234);
        repeat (300) @(posedge clk);
        check(cnt_l == n0, "R10", cnt_l, n0, "no frame without start bit");
        reg_read(0, 2'd1, v); check(v == 32'h1000_1234, "R10", v, 32'h1000_1234, "stored word");
        reg_read(0, 2'd0, v); check(v[8] == 1'b1, "R10", v[8], 1, "flag unchanged");

        // R8 extended write then read
        c = 32'h4000_0000 | (32'h1 << 28) | (32'h07 << 23) | (32'h0A << 18) | (32'h1 << 17) | 32'hBEEF;
        issue(1, c, 1'b1, 1);
        wait_done(1);
        check(q_e.size() == 0, "R8", q_e.size(), 0, "select and access frames seen");
        rdv_e = 16'h5A0F;
        c = 32'h4000_0000 | (32'h1 << 29) | (32'h1A << 23) | (32'h13 << 18) | (32'h1 << 17);
        issue(1, c, 1'b0, 0);
        wait_done(1);
        reg_read(1, 2'd1, v);
        check(v == {c[31:16], 16'h5A0F}, "R8", v, {c[31:16], 16'h5A0F}, "ext read data");
        check(cnt_e == 4, "R8", cnt_e, 4, "ext frame count");

        repeat (20) @(posedge clk);
        check(q_l.size() == 0, "R4", q_l.size(), 0, "legacy frames all seen");
        check(viol_l == 0, "R9", viol_l, 0, "legacy line moved while MDC high");
        check(viol_e == 0, "R9", viol_e, 0, "ext line moved while MDC high");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule